// File: doc/BRIEF.md
# NAND Command Cycle Sequencer

This block turns a captured flash command, held in three 32-bit words, into the bus cycles a NAND device expects. Word 0 is decoded into a first and second command byte, a command type, a chip select, an address cycle count and a flag that requests the second command byte. Words 1 and 2 supply the address bytes. The block then drives one command-latch cycle, the requested address-latch cycles, an optional second command cycle and a busy wait. It ends by reporting a read-data request, a command-done strobe or a timeout.

A front-end loads the three words and pulses `start`. Write-enable low and high widths and the busy-wait length are given in controller clock cycles. For a program command, the sequencer stops after the address cycles and raises a write-data request. It issues the closing command byte only after the front-end reports, with `data_done`, that the page data has been supplied. The ready line of the device is polled after the busy wait. If ready stays low too long, the command is marked as failed.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset, and whenever no command is running, `busy` is 0, `nand_we_n` is 1, `nand_cle`, `nand_ale`, `wr_req`, `rd_req`, `cmd_done` and `bad_blk` are 0, `nand_io` is 0 and `nand_ce_n` is 2'b11. A `start` sampled while idle makes `busy` 1 from the next cycle until the cycle after the final strobe.
- R2: A command runs in this order. First comes one command cycle with `nand_cle` high carrying word 0 bits 7:0. Then come N address cycles with `nand_ale` high, where N is word 0 bits 18:16 (0 to 7). Last comes one command cycle carrying word 0 bits 15:8, issued only when word 0 bit 19 is set.
- R3: Address cycle k (counting from 0) carries byte k of word 1 for k < 4, so the least significant byte goes first. For k ≥ 4 it carries byte k-4 of word 2.
- R4: When the command type (word 0 bits 23:21) is 2 (erase), exactly three address cycles are issued from word 1 bytes 0, 1 and 2, whatever the count field holds.
- R5: Every command or address cycle holds `nand_we_n` low for `t_wp`+1 clocks and then high for `t_wh`+1 clocks. `nand_io`, `nand_cle` and `nand_ale` stay constant across the whole cycle.
- R6: While busy, `nand_ce_n` is 2'b10 when word 0 bit 24 is 0 and 2'b01 when it is 1.
- R7: For type 1 (program), `wr_req` is high from the cycle after the last address cycle. It stays high up to and including the cycle in which `data_done` is sampled high. The second command cycle, or the busy wait, starts on the next cycle.
- R8: After the last bus cycle there are `t_r`+1 idle clocks, followed by one poll of `nand_rdy` per clock. For types 0, 3 and 4 (read, read ID, read status), `rd_req` pulses for one clock on the cycle after ready is sampled high.
- R9: For types 1, 2, 5, 6 and 7, `cmd_done` pulses for one clock on the cycle after ready is sampled high, and `rd_req` stays 0.
- R10: If `nand_rdy` is low for TIMEOUT_CYC consecutive polls, `bad_blk` and `cmd_done` pulse together for one clock and `rd_req` stays 0.
- R11: A `start` pulse, or changed command words, during a running command have no effect on that command's bus cycles or strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a command, sampled when idle |
| cmd_w0 | input | 32 | Command bytes, flags, type, count, chip select |
| cmd_w1 | input | 32 | Address bytes 0 to 3 |
| cmd_w2 | input | 32 | Address bytes 4 to 7 |
| t_wp | input | PW | Write-enable low width minus one |
| t_wh | input | PW | Write-enable high width minus one |
| t_r | input | TRW | Busy wait length minus one |
| data_done | input | 1 | Program data supplied |
| nand_rdy | input | 1 | Device ready, high when ready |
| busy | output | 1 | Command in progress |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_io | output | 8 | Command or address byte |
| nand_ce_n | output | 2 | Chip enables, active low |
| wr_req | output | 1 | Write-data request (program) |
| rd_req | output | 1 | Read-data request strobe |
| cmd_done | output | 1 | Command complete strobe |
| bad_blk | output | 1 | Ready timeout strobe |

## Verification
The bench aims at the corner cases where an off-by-one is easy to make. These include zero address cycles, the full count of seven that crosses into word 2, and the smallest and largest pulse widths: a sequencer that mis-counts would shorten a strobe or send a byte from the wrong word. Erase is given a count field of five, so a design that ignored the override would send two extra address cycles. Program is held in its write-request state for several cycles before data arrives, and is also released at once, which catches an early second command. Ready is withheld past the timeout to expose a missing bad-block strobe or a stray read request. A second start with altered words is injected mid-command, so a design that re-latched would change the bytes on the bus.

// File: rtl/nand_seq_pkg.sv
// Shared types for the NAND command sequencer.
// Assumes command word 0 uses the field layout stated in the brief.
package nand_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD1,
        ST_ADDR,
        ST_WDATA,
        ST_CMD2,
        ST_TR,
        ST_POLL,
        ST_FIN
    } seq_state_t;

    typedef struct packed {
        logic [7:0] cmd1;
        logic [7:0] cmd2;
        logic       dbl;
        logic [2:0] naddr;
        logic [2:0] ctype;
        logic       csel;
    } cmd_fields_t;

    localparam logic [2:0] CT_READ   = 3'd0;
    localparam logic [2:0] CT_PROG   = 3'd1;
    localparam logic [2:0] CT_ERASE  = 3'd2;
    localparam logic [2:0] CT_RDID   = 3'd3;
    localparam logic [2:0] CT_STATUS = 3'd4;

endpackage

// File: rtl/nand_seq_decode.sv
// Splits command word 0 into the fields the sequencer needs.
// Forces three address cycles for erase. Classifies read-type and program commands.
module nand_seq_decode
    import nand_seq_pkg::*;
(
    input  logic [31:0]  w0,
    output cmd_fields_t  fld,
    output logic         is_read,
    output logic         is_prog
);
    // Field extraction and classification
    always_comb begin
        fld.cmd1  = w0[7:0];
        fld.cmd2  = w0[15:8];
        fld.dbl   = w0[19];
        fld.ctype = w0[23:21];
        fld.csel  = w0[24];
        fld.naddr = (w0[23:21] == CT_ERASE) ? 3'd3 : w0[18:16];
        is_read   = (fld.ctype == CT_READ) || (fld.ctype == CT_RDID) ||
                    (fld.ctype == CT_STATUS);
        is_prog   = (fld.ctype == CT_PROG);
    end
endmodule

// File: rtl/nand_seq_addr_mux.sv
// Picks address byte idx: bytes 0-3 come from word 1, bytes 4-7 from word 2.
// Assumes 32-bit words; the least significant byte goes first.
module nand_seq_addr_mux #(
    parameter int WW = 32
) (
    input  logic [WW-1:0] w1,
    input  logic [WW-1:0] w2,
    input  logic [2:0]    idx,
    output logic [7:0]    abyte
);
    localparam int BPW = WW / 8;

    logic [7:0] lo_bytes [BPW];
    logic [7:0] hi_bytes [BPW];

    // Slice both words into byte lanes
    for (genvar g = 0; g < BPW; g++) begin : g_lane
        assign lo_bytes[g] = w1[g*8 +: 8];
        assign hi_bytes[g] = w2[g*8 +: 8];
    end

    // Select the lane by index, word chosen by the index MSB
    always_comb begin
        abyte = idx[2] ? hi_bytes[idx[1:0]] : lo_bytes[idx[1:0]];
    end
endmodule

// File: rtl/nand_seq_pulse.sv
// Times one write-enable pulse: low for t_low+1 clocks, then high for t_high+1 clocks.
// Restarts in the low phase whenever run drops. Flags the final clock of each pulse.
module nand_seq_pulse #(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] t_low,
    input  logic [PW-1:0] t_high,
    output logic          we_high,
    output logic          last
);
    logic [PW-1:0] cnt;
    logic          phase;

    // Phase counter: counts each phase width, then toggles the phase
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (!phase) begin
            if (cnt == t_low) begin
                cnt   <= '0;
                phase <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            if (cnt == t_high) begin
                cnt   <= '0;
                phase <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign we_high = phase;
    assign last    = run && phase && (cnt == t_high);
endmodule

// File: rtl/nand_cmd_seq.sv
// Runs one NAND command: command cycle, address cycles, optional program data
// hand-off, optional second command, busy wait, ready poll and a final strobe.
// Assumes start is honoured only while idle. The command words are latched at start.
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int PW          = 3,
    parameter int TRW         = 16,
    parameter int TIMEOUT_CYC = 256
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [31:0]    cmd_w0,
    input  logic [31:0]    cmd_w1,
    input  logic [31:0]    cmd_w2,
    input  logic [PW-1:0]  t_wp,
    input  logic [PW-1:0]  t_wh,
    input  logic [TRW-1:0] t_r,
    input  logic           data_done,
    input  logic           nand_rdy,
    output logic           busy,
    output logic           nand_cle,
    output logic           nand_ale,
    output logic           nand_we_n,
    output logic [7:0]     nand_io,
    output logic [1:0]     nand_ce_n,
    output logic           wr_req,
    output logic           rd_req,
    output logic           cmd_done,
    output logic           bad_blk
);
    localparam int TOW    = $clog2(TIMEOUT_CYC + 1);
    localparam int WAIT_W = (TRW > TOW) ? TRW : TOW;

    seq_state_t        state;
    logic [31:0]       w0_q, w1_q, w2_q;
    logic [2:0]        aidx;
    logic [WAIT_W-1:0] wcnt;
    logic              tmo;

    cmd_fields_t fld;
    logic        is_read, is_prog;
    logic [7:0]  abyte;
    logic        run, we_high, last;
    seq_state_t  post_addr;

    nand_seq_decode u_dec (.w0(w0_q), .fld(fld), .is_read(is_read), .is_prog(is_prog));

    nand_seq_addr_mux #(.WW(32)) u_amux (.w1(w1_q), .w2(w2_q), .idx(aidx), .abyte(abyte));

    nand_seq_pulse #(.PW(PW)) u_pulse (
        .clk(clk), .rst_n(rst_n), .run(run), .t_low(t_wp), .t_high(t_wh),
        .we_high(we_high), .last(last)
    );

    // Bus states are the ones that drive a write-enable pulse
    assign run = (state == ST_CMD1) || (state == ST_ADDR) || (state == ST_CMD2);

    // Where to go once the address phase is over
    always_comb begin
        if (is_prog)      post_addr = ST_WDATA;
        else if (fld.dbl) post_addr = ST_CMD2;
        else              post_addr = ST_TR;
    end

    // Main sequence register and its counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            w0_q  <= '0;
            w1_q  <= '0;
            w2_q  <= '0;
            aidx  <= '0;
            wcnt  <= '0;
            tmo   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    wcnt <= '0;
                    tmo  <= 1'b0;
                    if (start) begin
                        w0_q  <= cmd_w0;
                        w1_q  <= cmd_w1;
                        w2_q  <= cmd_w2;
                        aidx  <= '0;
                        state <= ST_CMD1;
                    end
                end
                ST_CMD1: begin
                    wcnt <= '0;
                    if (last) state <= (fld.naddr != 3'd0) ? ST_ADDR : post_addr;
                end
                ST_ADDR: begin
                    wcnt <= '0;
                    if (last) begin
                        if (aidx == fld.naddr - 3'd1) state <= post_addr;
                        else                          aidx  <= aidx + 3'd1;
                    end
                end
                ST_WDATA: begin
                    wcnt <= '0;
                    if (data_done) state <= fld.dbl ? ST_CMD2 : ST_TR;
                end
                ST_CMD2: begin
                    wcnt <= '0;
                    if (last) state <= ST_TR;
                end
                ST_TR: begin
                    if (wcnt == WAIT_W'(t_r)) begin
                        wcnt  <= '0;
                        state <= ST_POLL;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                ST_POLL: begin
                    if (nand_rdy) begin
                        tmo   <= 1'b0;
                        state <= ST_FIN;
                    end else if (wcnt == WAIT_W'(TIMEOUT_CYC - 1)) begin
                        tmo   <= 1'b1;
                        state <= ST_FIN;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                default: begin
                    wcnt  <= '0;
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Bus and strobe outputs decoded from the current state
    always_comb begin
        busy      = (state != ST_IDLE);
        nand_cle  = (state == ST_CMD1) || (state == ST_CMD2);
        nand_ale  = (state == ST_ADDR);
        nand_we_n = run ? we_high : 1'b1;
        case (state)
            ST_CMD1: nand_io = fld.cmd1;
            ST_CMD2: nand_io = fld.cmd2;
            ST_ADDR: nand_io = abyte;
            default: nand_io = 8'h00;
        endcase
        nand_ce_n = !busy ? 2'b11 : (fld.csel ? 2'b01 : 2'b10);
        wr_req    = (state == ST_WDATA);
        rd_req    = (state == ST_FIN) && !tmo && is_read;
        cmd_done  = (state == ST_FIN) && (tmo || !is_read);
        bad_blk   = (state == ST_FIN) && tmo;
    end
endmodule

// File: rtl/nand_cmd_seq_chk.sv
// Property checker for the NAND command sequencer, bound to every instance.
module nand_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_we_n,
    input logic [7:0] nand_io,
    input logic [1:0] nand_ce_n,
    input logic       wr_req,
    input logic       rd_req,
    input logic       cmd_done,
    input logic       bad_blk
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nand_we_n && !nand_cle && !nand_ale && nand_io == 8'h00 &&
                   !wr_req && !rd_req && !cmd_done && nand_ce_n == 2'b11));

    // R2
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    // R5
    io_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && !$past(nand_we_n)) |-> ($stable(nand_io) && $stable(nand_cle)));

    // R6
    one_chip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(nand_ce_n) == 1));

    // R7
    wreq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (nand_we_n && !nand_cle && !nand_ale));

    // R8
    finish_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || cmd_done) |=> !busy);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && cmd_done));

    // R10
    bad_has_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_blk |-> (cmd_done && !rd_req));

    // R11
    restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !rd_req && !cmd_done) |=> busy);
endmodule

bind nand_cmd_seq nand_cmd_seq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_io(nand_io), .nand_ce_n(nand_ce_n), .wr_req(wr_req),
    .rd_req(rd_req), .cmd_done(cmd_done), .bad_blk(bad_blk)
);

// File: tb/nand_cmd_seq_tb_top.sv
// Bench: builds the expected per-cycle bus trace of each command in a queue
// and compares every output with it on every clock.
module nand_cmd_seq_tb_top;
    localparam int TO = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cmd_w0 = '0, cmd_w1 = '0, cmd_w2 = '0;
    logic [2:0]  t_wp = '0, t_wh = '0;
    logic [15:0] t_r = '0;
    logic        data_done = 1'b0, nand_rdy = 1'b0;
    logic        busy, nand_cle, nand_ale, nand_we_n, wr_req, rd_req, cmd_done, bad_blk;
    logic [7:0]  nand_io;
    logic [1:0]  nand_ce_n;

    int errors = 0;
    int checks = 0;

    typedef struct packed {
        logic       busy, cle, ale, we_n;
        logic [7:0] io;
        logic [1:0] ce_n;
        logic       wr, rd, done, bad;
    } exp_t;

    exp_t exp_q[$];
    int   d_off, r_off;

    always #10 clk = ~clk;

    nand_cmd_seq #(.PW(3), .TRW(16), .TIMEOUT_CYC(TO)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_w0(cmd_w0), .cmd_w1(cmd_w1),
        .cmd_w2(cmd_w2), .t_wp(t_wp), .t_wh(t_wh), .t_r(t_r), .data_done(data_done),
        .nand_rdy(nand_rdy), .busy(busy), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_io(nand_io), .nand_ce_n(nand_ce_n), .wr_req(wr_req),
        .rd_req(rd_req), .cmd_done(cmd_done), .bad_blk(bad_blk)
    );

    task automatic chk(input string tag, input string fld, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, fld, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag, input exp_t e);
        chk({tag, " R1"}, "busy", busy, e.busy);
        chk({tag, " R2"}, "cle", nand_cle, e.cle);
        chk({tag, " R2"}, "ale", nand_ale, e.ale);
        chk({tag, " R5"}, "we_n", nand_we_n, e.we_n);
        chk({tag, " R3"}, "io", nand_io, e.io);
        chk({tag, " R6"}, "ce_n", nand_ce_n, e.ce_n);
        chk({tag, " R7"}, "wr_req", wr_req, e.wr);
        chk({tag, " R8"}, "rd_req", rd_req, e.rd);
        chk({tag, " R9"}, "cmd_done", cmd_done, e.done);
        chk({tag, " R10"}, "bad_blk", bad_blk, e.bad);
    endtask

    function automatic exp_t blank(input logic [1:0] ce);
        exp_t e;
        e = '0;
        e.busy = 1'b1;
        e.we_n = 1'b1;
        e.ce_n = ce;
        return e;
    endfunction

    task automatic bus_item(input logic cle, input logic ale, input logic [7:0] b,
                            input logic [1:0] ce, input int lo, input int hi);
        exp_t e;
        e = blank(ce);
        e.cle = cle;
        e.ale = ale;
        e.io  = b;
        e.we_n = 1'b0;
        for (int i = 0; i <= lo; i++) exp_q.push_back(e);
        e.we_n = 1'b1;
        for (int i = 0; i <= hi; i++) exp_q.push_back(e);
    endtask

    // Expected trace from the requirements
    task automatic build(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2,
                         input int lo, input int hi, input int tr, input int ddg, input int rg);
        logic [1:0] ce;
        int typ, n, p;
        bit rd_type, ok;
        exp_t e;
        exp_q.delete();
        ce = w0[24] ? 2'b01 : 2'b10;
        typ = int'(w0[23:21]);
        n = (typ == 2) ? 3 : int'(w0[18:16]);
        rd_type = (typ == 0) || (typ == 3) || (typ == 4);
        d_off = -1;
        bus_item(1'b1, 1'b0, w0[7:0], ce, lo, hi);
        for (int k = 0; k < n; k++)
            bus_item(1'b0, 1'b1, (k < 4) ? 8'(w1 >> (8*k)) : 8'(w2 >> (8*(k-4))), ce, lo, hi);
        if (typ == 1) begin
            d_off = exp_q.size() + ddg;
            e = blank(ce);
            e.wr = 1'b1;
            for (int i = 0; i <= ddg; i++) exp_q.push_back(e);
        end
        if (w0[19]) bus_item(1'b1, 1'b0, w0[15:8], ce, lo, hi);
        e = blank(ce);
        for (int i = 0; i <= tr; i++) exp_q.push_back(e);
        p = exp_q.size();
        r_off = p + rg;
        ok = (rg <= TO - 1);
        for (int i = 0; i < (ok ? rg + 1 : TO); i++) exp_q.push_back(e);
        e.rd   = ok && rd_type;
        e.done = !ok || !rd_type;
        e.bad  = !ok;
        exp_q.push_back(e);
    endtask

    task automatic check_idle(input string tag);
        exp_t e;
        e = '0;
        e.we_n = 1'b1;
        e.ce_n = 2'b11;
        compare(tag, e);
    endtask

    task automatic run_cmd(input string tag, input logic [31:0] w0, input logic [31:0] w1,
                           input logic [31:0] w2, input int lo, input int hi, input int tr,
                           input int ddg, input int rg, input bit inject);
        build(w0, w1, w2, lo, hi, tr, ddg, rg);
        @(negedge clk);
        cmd_w0 = w0; cmd_w1 = w1; cmd_w2 = w2;
        t_wp = 3'(lo); t_wh = 3'(hi); t_r = 16'(tr);
        nand_rdy = 1'b0; data_done = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int off = 0; exp_q.size() > 0; off++) begin
            compare(tag, exp_q.pop_front());
            nand_rdy  = (off >= r_off);
            data_done = (off == d_off);
            if (inject && off == 3) begin
                start = 1'b1;
                cmd_w0 = ~w0; cmd_w1 = ~w1; cmd_w2 = ~w2;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        data_done = 1'b0;
        nand_rdy = 1'b0;
        check_idle({tag, " end R1"});
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R1: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("reset R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("post-reset R1");
        // R2 R3 R8: read with second command, five address cycles reaching word 2
        run_cmd("read5 R3", {7'd0, 1'b0, 3'd0, 1'b0, 1'b1, 3'd5, 8'h30, 8'h00},
                32'h44332211, 32'h000000A5, 1, 0, 3, 0, 2, 1'b0);
        // R7 R6: program on chip 1, data arrives after a delay
        run_cmd("prog R7", {7'd0, 1'b1, 3'd1, 1'b0, 1'b1, 3'd4, 8'h10, 8'h80},
                32'hDEADBEEF, 32'h0, 0, 1, 2, 4, 1, 1'b0);
        // R7: program without second command, data at once
        run_cmd("prog-nodbl R7", {7'd0, 1'b0, 3'd1, 1'b0, 1'b0, 3'd2, 8'h10, 8'h80},
                32'h00005A3C, 32'h0, 0, 0, 0, 0, 0, 1'b0);
        // R4 R9: erase with count field 5 must still send three address bytes
        run_cmd("erase R4", {7'd0, 1'b0, 3'd2, 1'b0, 1'b1, 3'd5, 8'hD0, 8'h60},
                32'h12345678, 32'h9ABCDEF0, 1, 1, 1, 0, 0, 1'b0);
        // R10: reset with ready never returning
        run_cmd("reset-timeout R10", {7'd0, 1'b0, 3'd5, 1'b0, 1'b0, 3'd0, 8'h00, 8'hFF},
                32'h0, 32'h0, 0, 0, 0, 0, TO + 10, 1'b0);
        // R5 R3: read ID, seven address cycles, widest pulses
        run_cmd("rdid7 R5", {7'd0, 1'b1, 3'd3, 1'b0, 1'b0, 3'd7, 8'h00, 8'h90},
                32'h04030201, 32'h00070605, 7, 7, 0, 0, 5, 1'b0);
        // R8: read status, no address cycles
        run_cmd("status R8", {7'd0, 1'b0, 3'd4, 1'b0, 1'b0, 3'd0, 8'h00, 8'h70},
                32'h0, 32'h0, 2, 3, 1, 0, 1, 1'b0);
        // R11 R9: type 7 with a restart injected mid-command
        run_cmd("restart R11", {7'd0, 1'b1, 3'd7, 1'b0, 1'b0, 3'd1, 8'h23, 8'h2A},
                32'h000000C3, 32'h0, 2, 1, 0, 0, 3, 1'b1);
        // R1: idle after a sequence of commands
        @(negedge clk);
        check_idle("final R1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule